// File: doc/BRIEF.md
# Two-Class Descriptor Classifier and Scheduler

This block sits behind a header parser and in front of a shared output path. Each incoming descriptor holds the parsed fields of one IP packet: the IP version, an address, the ToS byte (the traffic class for IPv6), the flow label, the protocol number and the UDP destination port. The block compares the descriptor against a small table of programmable rules and sorts it into one of two classes, high or low. It then writes the descriptor into the FIFO for that class.

A rule names an IP version and an address. It can also name a ToS value, a UDP port, or, for IPv6, a flow label. Each field of a rule has its own enable bit, and a field whose enable is clear is ignored. A descriptor that hits any enabled rule is high priority, and every other descriptor is low priority.

The output side serves the two FIFOs with strict priority. The output shows the head of the high FIFO whenever that FIFO holds anything. The low FIFO is read only when the high FIFO is empty. When the FIFO that an incoming descriptor would go to is full, the input is stalled, so no descriptor is ever lost.

Top module: `prio_sched_top`

## Requirements
- R1: After reset both FIFOs are empty. `outValid` is 0, `inReady` is 1, and every rule slot is invalid, so the first descriptors are all classified low (`outHigh` = 0).
- R2: A valid rule with the address and UDP-port enables set classifies an IPv4 descriptor as high when all of the following hold: the address matches, `inProto` = 17 (UDP) and `inPort` matches.
- R3: A valid IPv4 rule with the address and ToS enables set matches on address and ToS. A rule that also has the UDP-port enable set additionally requires UDP with a matching port.
- R4: A valid IPv6 rule with the address, ToS and flow enables set matches an IPv6 descriptor on address, traffic class (`inTos`) and flow label. A rule never matches a descriptor whose version bit (`inIsV6`, 1 = IPv6) differs from its own.
- R5: A field whose enable bit is clear takes no part in the comparison. A rule slot written with `ruleValid` = 0 never matches.
- R6: A descriptor whose protocol is not 17 never matches a rule that has the UDP-port enable set.
- R7: A descriptor that hits at least one valid rule is emitted with `outHigh` = 1. A descriptor that hits none is emitted with `outHigh` = 0. Descriptor fields pass through unchanged.
- R8: While the high FIFO holds a descriptor, the output presents that descriptor with `outHigh` = 1. The low FIFO is dequeued only in cycles where the high FIFO is empty.
- R9: `inReady` is 0 exactly when the FIFO of the presented descriptor's class holds DEPTH entries. Accepted descriptors leave each class in arrival order, and none is dropped.
- R10: A descriptor accepted at a clock edge appears at the output after that edge, never in the same cycle. A rule write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ruleWe | input | 1 | Write one rule slot this cycle |
| ruleIdx | input | IDX_W | Rule slot to write |
| ruleValid | input | 1 | Slot takes part in matching |
| ruleIsV6 | input | 1 | Rule version, 1 = IPv6 |
| ruleUseAddr | input | 1 | Compare address |
| ruleUseTos | input | 1 | Compare ToS / traffic class |
| ruleUsePort | input | 1 | Require UDP and compare port |
| ruleUseFlow | input | 1 | Compare flow label (IPv6 only) |
| ruleAddr | input | 128 | Rule address (IPv4 in bits 31:0, upper bits zero) |
| ruleTos | input | 8 | Rule ToS / traffic class |
| rulePort | input | 16 | Rule UDP destination port |
| ruleFlow | input | 20 | Rule flow label |
| inValid | input | 1 | Descriptor presented |
| inReady | output | 1 | Descriptor accepted at the edge when also valid |
| inIsV6 | input | 1 | Descriptor version, 1 = IPv6 |
| inAddr | input | 128 | Descriptor address |
| inTos | input | 8 | ToS / traffic class |
| inFlow | input | 20 | Flow label |
| inProto | input | 8 | Protocol number (17 = UDP) |
| inPort | input | 16 | UDP destination port |
| outValid | output | 1 | Output descriptor available |
| outReady | input | 1 | Consumer takes the output at the edge |
| outHigh | output | 1 | Class of the output descriptor, 1 = high |
| outIsV6 | output | 1 | Output version bit |
| outAddr | output | 128 | Output address |
| outTos | output | 8 | Output ToS |
| outFlow | output | 20 | Output flow label |
| outProto | output | 8 | Output protocol |
| outPort | output | 16 | Output UDP port |

## Verification
The assertions assume that every input is at a known level from the first edge after reset and that the consumer may hold `outReady` low for any length of time. A high head that is stalled must therefore stay in place. They also assume that the port-level occupancy count (accepts minus pops) tracks the two FIFOs, which holds only if no descriptor is created or lost inside the block. The stimulus changes inputs just after each edge. It writes rules only while no descriptor is in flight, and it sweeps every combination of version, address, protocol, port, ToS and flow label against a fixed four-rule table. After that it fills both FIFOs with the consumer stalled and then drains them.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int ADDR_W  = 128;
  localparam int TOS_W   = 8;
  localparam int FLOW_W  = 20;
  localparam int PROTO_W = 8;
  localparam int PORT_W  = 16;
  localparam logic [PROTO_W-1:0] UDP_PROTO = 8'd17;

  typedef struct packed {
    logic               isV6;
    logic [ADDR_W-1:0]  addr;
    logic [TOS_W-1:0]   tos;
    logic [FLOW_W-1:0]  flow;
    logic [PROTO_W-1:0] proto;
    logic [PORT_W-1:0]  port;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef struct packed {
    logic              valid;
    logic              isV6;
    logic              useAddr;
    logic              useTos;
    logic              usePort;
    logic              useFlow;
    logic [ADDR_W-1:0] addr;
    logic [TOS_W-1:0]  tos;
    logic [PORT_W-1:0] port;
    logic [FLOW_W-1:0] flow;
  } rule_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pushHi;
    logic pushLo;
    logic popHi;
    logic popLo;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isHigh;
    logic hiFull;
    logic loFull;
    logic hiEmpty;
    logic loEmpty;
  } status_t;

  function automatic logic ruleHit(rule_t r, desc_t d);
    logic ok;
    ok = r.valid && (r.isV6 == d.isV6);
    if (r.useAddr && (r.addr != d.addr)) ok = 1'b0;
    if (r.useTos && (r.tos != d.tos)) ok = 1'b0;
    if (r.usePort && ((d.proto != UDP_PROTO) || (r.port != d.port))) ok = 1'b0;
    if (r.useFlow && (!d.isV6 || (r.flow != d.flow))) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/prio_fifo.sv
module prio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int DEPTH     = 4,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ruleWe,
  input  logic [IDX_W-1:0] ruleIdx,
  input  rule_t            wrRule,
  input  desc_t            inDesc,
  input  strobe_t          strb,
  output status_t          stat,
  output desc_t            outDesc
);
  rule_t ruleTab [NUM_RULES];
  logic [NUM_RULES-1:0] hitVec;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ruleTab[i].valid <= 1'b0;
      end else if (ruleWe && (ruleIdx == IDX_W'(i))) begin
        ruleTab[i] <= wrRule;
      end
    end
    assign hitVec[i] = ruleHit(ruleTab[i], inDesc);
  end

  // queue 0 = high, queue 1 = low
  logic       qPush [2];
  logic       qPop  [2];
  logic       qFull [2];
  logic       qEmpty[2];
  logic [DESC_W-1:0] qHead[2];

  assign qPush[0] = strb.pushHi;
  assign qPush[1] = strb.pushLo;
  assign qPop[0]  = strb.popHi;
  assign qPop[1]  = strb.popLo;

  for (genvar q = 0; q < 2; q++) begin : g_queue
    prio_fifo #(.W(DESC_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rstN(rstN),
      .push(qPush[q]), .pushData(inDesc),
      .pop(qPop[q]), .popData(qHead[q]),
      .full(qFull[q]), .empty(qEmpty[q])
    );
  end

  assign stat.isHigh  = |hitVec;
  assign stat.hiFull  = qFull[0];
  assign stat.loFull  = qFull[1];
  assign stat.hiEmpty = qEmpty[0];
  assign stat.loEmpty = qEmpty[1];
  assign outDesc      = qEmpty[0] ? desc_t'(qHead[1]) : desc_t'(qHead[0]);
endmodule

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
(
  input  logic    inValid,
  output logic    inReady,
  input  logic    outReady,
  output logic    outValid,
  output logic    outHigh,
  input  status_t stat,
  output strobe_t strb
);
  logic roomHi, roomLo;

  assign roomHi   = !stat.hiFull;
  assign roomLo   = !stat.loFull;
  assign inReady  = stat.isHigh ? roomHi : roomLo;
  assign outHigh  = !stat.hiEmpty;
  assign outValid = !stat.hiEmpty || !stat.loEmpty;

  always_comb begin
    strb        = '0;
    strb.pushHi = inValid && stat.isHigh && roomHi;
    strb.pushLo = inValid && !stat.isHigh && roomLo;
    strb.popHi  = outReady && !stat.hiEmpty;
    strb.popLo  = outReady && stat.hiEmpty && !stat.loEmpty;
  end
endmodule

// File: rtl/prio_sched_top.sv
module prio_sched_top
  import prio_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int DEPTH     = 4,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ruleWe,
  input  logic [IDX_W-1:0]   ruleIdx,
  input  logic               ruleValid,
  input  logic               ruleIsV6,
  input  logic               ruleUseAddr,
  input  logic               ruleUseTos,
  input  logic               ruleUsePort,
  input  logic               ruleUseFlow,
  input  logic [127:0]       ruleAddr,
  input  logic [7:0]         ruleTos,
  input  logic [15:0]        rulePort,
  input  logic [19:0]        ruleFlow,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inIsV6,
  input  logic [127:0]       inAddr,
  input  logic [7:0]         inTos,
  input  logic [19:0]        inFlow,
  input  logic [7:0]         inProto,
  input  logic [15:0]        inPort,
  output logic               outValid,
  input  logic               outReady,
  output logic               outHigh,
  output logic               outIsV6,
  output logic [127:0]       outAddr,
  output logic [7:0]         outTos,
  output logic [19:0]        outFlow,
  output logic [7:0]         outProto,
  output logic [15:0]        outPort
);
  rule_t   wrRule;
  desc_t   inDesc, outDesc;
  strobe_t strb;
  status_t stat;

  assign wrRule = '{valid: ruleValid, isV6: ruleIsV6, useAddr: ruleUseAddr,
                    useTos: ruleUseTos, usePort: ruleUsePort, useFlow: ruleUseFlow,
                    addr: ruleAddr, tos: ruleTos, port: rulePort, flow: ruleFlow};
  assign inDesc = '{isV6: inIsV6, addr: inAddr, tos: inTos, flow: inFlow,
                    proto: inProto, port: inPort};

  prio_datapath #(.NUM_RULES(NUM_RULES), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .ruleWe(ruleWe), .ruleIdx(ruleIdx),
    .wrRule(wrRule), .inDesc(inDesc), .strb(strb), .stat(stat),
    .outDesc(outDesc)
  );

  prio_ctrl ctrl_i (
    .inValid(inValid), .inReady(inReady), .outReady(outReady),
    .outValid(outValid), .outHigh(outHigh), .stat(stat), .strb(strb)
  );

  assign outIsV6  = outDesc.isV6;
  assign outAddr  = outDesc.addr;
  assign outTos   = outDesc.tos;
  assign outFlow  = outDesc.flow;
  assign outProto = outDesc.proto;
  assign outPort  = outDesc.port;
endmodule

// File: rtl/prio_sched_chk.sv
module prio_sched_chk
  import prio_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(2 * DEPTH + 1) + 1
) (
  input logic    clk,
  input logic    rstN,
  input logic    inValid,
  input logic    inReady,
  input logic    outValid,
  input logic    outReady,
  input logic    outHigh,
  input strobe_t strb,
  input status_t stat
);
  logic [PW-1:0] pend;
  logic acc, deq;

  assign acc = inValid && inReady;
  assign deq = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= pend + PW'(acc) - PW'(deq);
  end

  // R8
  low_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.popLo |-> stat.hiEmpty);

  // R8
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHigh && !outReady) |=> (outValid && outHigh));

  // R9
  hi_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushHi |-> !stat.hiFull);

  // R9
  lo_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushLo |-> !stat.loFull);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend <= PW'(2 * DEPTH));

  // R10
  out_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pend != '0));
endmodule

bind prio_sched_top prio_sched_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outHigh(outHigh),
  .strb(strb), .stat(stat)
);

// File: tb/prio_sched_top_tb_top.sv
module prio_sched_top_tb_top;
  localparam int NR = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic ruleWe = 0, ruleValid = 0, ruleIsV6 = 0;
  logic ruleUseAddr = 0, ruleUseTos = 0, ruleUsePort = 0, ruleUseFlow = 0;
  logic [1:0] ruleIdx = 0;
  logic [127:0] ruleAddr = 0;
  logic [7:0] ruleTos = 0;
  logic [15:0] rulePort = 0;
  logic [19:0] ruleFlow = 0;
  logic inValid = 0, inIsV6 = 0, outReady = 0;
  logic [127:0] inAddr = 0;
  logic [7:0] inTos = 0, inProto = 0;
  logic [19:0] inFlow = 0;
  logic [15:0] inPort = 0;
  logic inReady, outValid, outHigh, outIsV6;
  logic [127:0] outAddr;
  logic [7:0] outTos, outProto;
  logic [19:0] outFlow;
  logic [15:0] outPort;

  prio_sched_top #(.NUM_RULES(NR), .DEPTH(DEPTH)) dut_i (.*);

  int nVec = 0, nBad = 0;

  // bench copy of the programmed rules
  bit rV[NR], rV6[NR], rUA[NR], rUT[NR], rUP[NR], rUF[NR];
  logic [127:0] rA[NR];
  logic [7:0] rT[NR];
  logic [15:0] rP[NR];
  logic [19:0] rF[NR];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic putRule(int idx, bit v, bit v6, logic [127:0] a, bit ua,
                         logic [7:0] t, bit ut, logic [15:0] p, bit up,
                         logic [19:0] f, bit uf);
    rV[idx] = v; rV6[idx] = v6; rA[idx] = a; rUA[idx] = ua;
    rT[idx] = t; rUT[idx] = ut; rP[idx] = p; rUP[idx] = up;
    rF[idx] = f; rUF[idx] = uf;
    ruleWe = 1; ruleIdx = 2'(idx); ruleValid = v; ruleIsV6 = v6;
    ruleAddr = a; ruleUseAddr = ua; ruleTos = t; ruleUseTos = ut;
    rulePort = p; ruleUsePort = up; ruleFlow = f; ruleUseFlow = uf;
    step();
    ruleWe = 0;
  endtask

  function automatic bit expHigh(bit v6, logic [127:0] a, logic [7:0] t,
                                 logic [19:0] f, logic [7:0] pr, logic [15:0] pt);
    bit h = 0;
    for (int i = 0; i < NR; i++) begin
      bit ok;
      ok = rV[i] && (rV6[i] == v6);
      if (rUA[i] && rA[i] != a) ok = 0;
      if (rUT[i] && rT[i] != t) ok = 0;
      if (rUP[i] && (pr != 8'd17 || rP[i] != pt)) ok = 0;
      if (rUF[i] && (!v6 || rF[i] != f)) ok = 0;
      h |= ok;
    end
    return h;
  endfunction

  task automatic drive(bit v6, logic [127:0] a, logic [7:0] t, logic [19:0] f,
                       logic [7:0] pr, logic [15:0] pt);
    inValid = 1; inIsV6 = v6; inAddr = a; inTos = t; inFlow = f;
    inProto = pr; inPort = pt;
    #1;
  endtask

  // one descriptor through an idle block with the consumer ready
  task automatic sendOne(string tag, bit v6, logic [127:0] a, logic [7:0] t,
                         logic [19:0] f, logic [7:0] pr, logic [15:0] pt);
    bit e;
    e = expHigh(v6, a, t, f, pr, pt);
    outReady = 1;
    drive(v6, a, t, f, pr, pt);
    chk({tag, " R9 ready"}, 128'(inReady), 128'(1));
    chk("R10 not same cycle", 128'(outValid), 128'(0));
    step();
    inValid = 0;
    chk({tag, " R7 valid"}, 128'(outValid), 128'(1));
    chk({tag, " R7 class"}, 128'(outHigh), 128'(e));
    chk({tag, " R7 addr"}, outAddr, a);
    chk({tag, " R7 flow"}, 128'(outFlow), 128'(f));
    step();
  endtask

  initial begin
    logic [127:0] addrs[5];
    logic [15:0] ports[3];
    logic [7:0] toses[4];
    logic [19:0] flows[2];
    logic [7:0] protos[2];
    addrs[0] = 128'h0A000001; addrs[1] = 128'h0A000002; addrs[2] = 128'h0A000003;
    addrs[3] = 128'h20010DB8_0000_0000_0000_0000_0000_0001;
    addrs[4] = 128'hC0A80001;
    ports[0] = 16'd5060; ports[1] = 16'd7000; ports[2] = 16'd9;
    toses[0] = 8'hB8; toses[1] = 8'h28; toses[2] = 8'h20; toses[3] = 8'h00;
    flows[0] = 20'h12345; flows[1] = 20'h00001;
    protos[0] = 8'd17; protos[1] = 8'd6;

    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 outValid", 128'(outValid), 128'(0));
    chk("R1 inReady", 128'(inReady), 128'(1));
    sendOne("R1 cleared table", 0, addrs[0], 8'hB8, 20'h1, 8'd17, 16'd5060);

    // R2 addr+port, R3 addr+tos and addr+tos+port, R4 IPv6 addr+tc+flow
    putRule(0, 1, 0, addrs[0], 1, 8'h00, 0, 16'd5060, 1, 20'h0, 0);
    putRule(1, 1, 0, addrs[1], 1, 8'hB8, 1, 16'd0, 0, 20'h0, 0);
    putRule(2, 1, 0, addrs[2], 1, 8'h28, 1, 16'd7000, 1, 20'h0, 0);
    putRule(3, 1, 1, addrs[3], 1, 8'h20, 1, 16'd0, 0, 20'h12345, 1);
    // sweep covers R2 R3 R4 R6 R7
    for (int v = 0; v < 2; v++)
      for (int ai = 0; ai < 5; ai++)
        for (int pi = 0; pi < 2; pi++)
          for (int si = 0; si < 3; si++)
            for (int ti = 0; ti < 4; ti++)
              for (int fi = 0; fi < 2; fi++)
                sendOne("R2/R3/R4/R6 sweep", bit'(v), addrs[ai], toses[ti],
                        flows[fi], protos[pi], ports[si]);

    // explicit corner cases
    sendOne("R2 udp port hit", 0, addrs[0], 8'h00, 20'h0, 8'd17, 16'd5060);
    sendOne("R6 tcp same port", 0, addrs[0], 8'h00, 20'h0, 8'd6, 16'd5060);
    sendOne("R4 v4 desc vs v6 rule", 0, addrs[3], 8'h20, 20'h12345, 8'd17, 16'd1);

    // R5 invalid slot never matches
    putRule(0, 0, 0, addrs[0], 1, 8'h00, 0, 16'd5060, 1, 20'h0, 0);
    sendOne("R5 invalid slot", 0, addrs[0], 8'h00, 20'h0, 8'd17, 16'd5060);
    // R5 all fields disabled: every IPv4 descriptor is high
    putRule(0, 1, 0, 128'h0, 0, 8'h00, 0, 16'd0, 0, 20'h0, 0);
    sendOne("R5 wildcard v4", 0, addrs[4], 8'h11, 20'h7, 8'd6, 16'd80);
    sendOne("R5 wildcard v6 miss", 1, addrs[4], 8'h11, 20'h7, 8'd6, 16'd80);

    // R9 fill both queues with the consumer stalled, R8 ordering on drain
    outReady = 0;
    for (int k = 0; k < DEPTH; k++) begin
      drive(1, addrs[4], 8'h0, 20'(100 + k), 8'd6, 16'd1);
      chk("R9 low room", 128'(inReady), 128'(1));
      step();
    end
    inValid = 0; #1;
    chk("R8 low only", 128'(outHigh), 128'(0));
    chk("R9 low order head", 128'(outFlow), 128'(100));
    drive(1, addrs[4], 8'h0, 20'd999, 8'd6, 16'd1);
    chk("R9 low full stalls", 128'(inReady), 128'(0));
    step();
    for (int k = 0; k < DEPTH; k++) begin
      drive(0, addrs[4], 8'h0, 20'(200 + k), 8'd6, 16'd1);
      chk("R9 high room", 128'(inReady), 128'(1));
      step();
      inValid = 0; #1;
      chk("R8 high first", 128'(outHigh), 128'(1));
    end
    drive(0, addrs[4], 8'h0, 20'd998, 8'd6, 16'd1);
    chk("R9 high full stalls", 128'(inReady), 128'(0));
    inValid = 0;
    step();
    outReady = 1; #1;
    for (int k = 0; k < 2 * DEPTH; k++) begin
      chk("R8 drain valid", 128'(outValid), 128'(1));
      chk("R8 drain class", 128'(outHigh), 128'(k < DEPTH));
      chk("R9 drain order", 128'(outFlow),
          128'(k < DEPTH ? 200 + k : 100 + k - DEPTH));
      step();
    end
    chk("R9 none extra", 128'(outValid), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule